// File: doc/BRIEF.md
# Writeback Pixel Format Packer

This block sits at the end of a compositor's writeback path. It accepts one pixel per handshake, carrying four 8-bit channels (alpha, red, green, blue), and turns the stream into 32-bit memory words in the layout named by a 4-bit format code. A word leaves the block with a 4-bit byte strobe, ready for a memory writer.

Three pixel sizes are supported. The 32-bit layouts keep every channel at full width. The 16-bit layouts cut channels to 4 bits, or to 5/6/5 bits, and place two pixels in each word. Alpha is either taken from the pixel, optionally inverted, or replaced by a constant fill. A 4-bit lane mask removes byte lanes from every strobe. An end-of-line marker flushes a lone 16-bit pixel. A format code outside the supported set discards pixels and sets a sticky error.

The configuration inputs (format, alpha controls, lane mask) are expected to stay constant while pixels are in flight.

Top module: `wbpk_packer`

## Requirements
- R1: The 32-bit codes place channels from bit 31 downward in 8-bit fields. Code 12 places A,B,G,R. Code 13 places A,R,G,B. Code 14 places B,G,R,A. Code 15 places R,G,B,A. Each pixel yields one word with strobe equal to the lane mask.
- R2: The 4444 codes 0,1,2,3 use the same channel orders as codes 12,13,14,15, in 4-bit fields from bit 15 downward. Each field holds the upper 4 bits of its channel. Two pixels form one word: the first pixel in bits 15:0, the second in bits 31:16.
- R3: Code 7 packs R[7:3] into bits 15:11, G[7:2] into bits 10:5 and B[7:3] into bits 4:0. Code 6 swaps R and B. Alpha is not stored. Pixels pair into words as in R2.
- R4: When alpha_store is 1, the alpha field takes the pixel's alpha. If alpha_invert is also 1, it takes the bitwise complement of that alpha. Both are truncated as in R2 for 4444.
- R5: When alpha_store is 0, every alpha bit is filled with alpha_invert. The fill is all ones when alpha_invert is 1 and all zeros when it is 0.
- R6: out_strb is the lane mask ANDed with the lanes that carry pixel data. Bit n of the mask and of the strobe covers bits 8n+7:8n.
- R7: A 16-bit pixel accepted with in_eol=1 and no waiting first pixel is emitted alone. Its data is in bits 15:0, bits 31:16 are zero, and the strobe is the lane mask ANDed with 4'b0011.
- R8: Codes 4, 5, 8, 9, 10 and 11 are unsupported. Pixels under these codes are still accepted but produce no word. They set fmt_error, which stays set until reset.
- R9: While out_valid is 1 and out_ready is 0, out_data and out_strb hold their values and in_ready is 0. A word appears the cycle after the handshake that completes it.
- R10: After reset, out_valid and fmt_error are 0, in_ready is 1, and no half-filled word is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_format | input | 4 | Format code |
| cfg_alpha_store | input | 1 | Store incoming alpha instead of a fill |
| cfg_alpha_invert | input | 1 | Invert stored alpha / select fill value |
| cfg_lane_mask | input | 4 | Byte-lane enable mask |
| in_valid | input | 1 | Pixel valid |
| in_ready | output | 1 | Pixel accepted when high with in_valid |
| in_alpha | input | 8 | Alpha channel |
| in_red | input | 8 | Red channel |
| in_green | input | 8 | Green channel |
| in_blue | input | 8 | Blue channel |
| in_eol | input | 1 | Last pixel of a line |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 32 | Packed word |
| out_strb | output | 4 | Byte strobes |
| fmt_error | output | 1 | Sticky unsupported-format flag |

## Verification
Two fixed pixels are used. Every channel of each has a different value and different upper and lower nibbles, so every supported code shows whether channels are swapped, shifted by a field, or truncated from the wrong end. For the 16-bit codes the two pixels also show whether the pair lands in the wrong halves. The alpha value is not symmetric under complement, so a stored, inverted, zero-filled or one-filled alpha each gives a different result. Directed cases cover partial lane masks, a lone end-of-line pixel, a half word discarded by reset, a stalled consumer and a stream under an unsupported code.

// File: rtl/wbpk_pkg.sv
package wbpk_pkg;
  localparam int CH_W   = 8;
  localparam int WORD_W = 32;
  localparam int LANE_N = WORD_W / 8;
  localparam int HALF_W = WORD_W / 2;
  localparam int FMT_W  = 4;
  localparam int NIB_W  = CH_W / 2;

  typedef enum logic [1:0] {
    CLS_BAD  = 2'd0,
    CLS_4444 = 2'd1,
    CLS_565  = 2'd2,
    CLS_8888 = 2'd3
  } fmt_class_e;

  // channel order, most significant slot first
  typedef enum logic [1:0] {
    ORD_ABGR = 2'd0,
    ORD_ARGB = 2'd1,
    ORD_BGRA = 2'd2,
    ORD_RGBA = 2'd3
  } ch_order_e;

  typedef struct packed {
    fmt_class_e cls;
    ch_order_e  order;
  } fmt_dec_t;
endpackage

// File: rtl/wbpk_fmt_decode.sv
module wbpk_fmt_decode
  import wbpk_pkg::*;
(
  input  logic [FMT_W-1:0] code,
  output fmt_dec_t         dec
);
  always_comb begin
    dec.order = ch_order_e'(code[1:0]);
    unique case (code)
      4'd0, 4'd1, 4'd2, 4'd3:     dec.cls = CLS_4444;
      4'd6, 4'd7:                 dec.cls = CLS_565;
      4'd12, 4'd13, 4'd14, 4'd15: dec.cls = CLS_8888;
      default:                    dec.cls = CLS_BAD;
    endcase
  end
endmodule

// File: rtl/wbpk_convert.sv
module wbpk_convert
  import wbpk_pkg::*;
(
  input  fmt_dec_t          dec,
  input  logic              alpha_store,
  input  logic              alpha_invert,
  input  logic [CH_W-1:0]   a_in,
  input  logic [CH_W-1:0]   r_in,
  input  logic [CH_W-1:0]   g_in,
  input  logic [CH_W-1:0]   b_in,
  output logic [WORD_W-1:0] pix_full,
  output logic [HALF_W-1:0] pix_half
);
  logic [CH_W-1:0] alpha_eff;
  logic [CH_W-1:0] slot [LANE_N];
  logic [HALF_W-1:0] p4444;
  logic [HALF_W-1:0] p565;

  always_comb begin
    if (alpha_store) alpha_eff = a_in ^ {CH_W{alpha_invert}};
    else             alpha_eff = {CH_W{alpha_invert}};
  end

  // slot[3] is the most significant channel
  always_comb begin
    unique case (dec.order)
      ORD_ABGR: begin slot[3] = alpha_eff; slot[2] = b_in; slot[1] = g_in; slot[0] = r_in; end
      ORD_ARGB: begin slot[3] = alpha_eff; slot[2] = r_in; slot[1] = g_in; slot[0] = b_in; end
      ORD_BGRA: begin slot[3] = b_in; slot[2] = g_in; slot[1] = r_in; slot[0] = alpha_eff; end
      default:  begin slot[3] = r_in; slot[2] = g_in; slot[1] = b_in; slot[0] = alpha_eff; end
    endcase
  end

  for (genvar i = 0; i < LANE_N; i++) begin : g_slot
    assign pix_full[i*CH_W +: CH_W] = slot[i];
    assign p4444[i*NIB_W +: NIB_W]  = slot[i][CH_W-1 -: NIB_W];
  end

  always_comb begin
    if (dec.order[0]) p565 = {r_in[CH_W-1 -: 5], g_in[CH_W-1 -: 6], b_in[CH_W-1 -: 5]};
    else              p565 = {b_in[CH_W-1 -: 5], g_in[CH_W-1 -: 6], r_in[CH_W-1 -: 5]};
  end

  assign pix_half = (dec.cls == CLS_565) ? p565 : p4444;
endmodule

// File: rtl/wbpk_assembler.sv
module wbpk_assembler
  import wbpk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  fmt_class_e        cls,
  input  logic [LANE_N-1:0] lane_mask,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_eol,
  input  logic [WORD_W-1:0] pix_full,
  input  logic [HALF_W-1:0] pix_half,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic [LANE_N-1:0] out_strb,
  output logic              fmt_error
);
  localparam logic [LANE_N-1:0] LOW_LANES = {{(LANE_N/2){1'b0}}, {(LANE_N/2){1'b1}}};

  logic              hold_q, hold_n;
  logic [HALF_W-1:0] half_q, half_n;
  logic              ov_n, err_n, load;
  logic [WORD_W-1:0] word_n;
  logic [LANE_N-1:0] strb_n;
  logic              accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    hold_n = hold_q;
    half_n = half_q;
    err_n  = fmt_error;
    load   = 1'b0;
    word_n = out_data;
    strb_n = out_strb;
    if (accept) begin
      unique case (cls)
        CLS_BAD: err_n = 1'b1;
        CLS_8888: begin
          load   = 1'b1;
          word_n = pix_full;
          strb_n = lane_mask;
        end
        default: begin
          if (hold_q) begin
            load   = 1'b1;
            word_n = {pix_half, half_q};
            strb_n = lane_mask;
            hold_n = 1'b0;
          end else if (in_eol) begin
            load   = 1'b1;
            word_n = {{HALF_W{1'b0}}, pix_half};
            strb_n = lane_mask & LOW_LANES;
          end else begin
            hold_n = 1'b1;
            half_n = pix_half;
          end
        end
      endcase
    end
    ov_n = load || (out_valid && !out_ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      hold_q    <= 1'b0;
      fmt_error <= 1'b0;
    end else begin
      out_valid <= ov_n;
      hold_q    <= hold_n;
      fmt_error <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      out_strb <= '0;
      half_q   <= '0;
    end else begin
      if (load) begin
        out_data <= word_n;
        out_strb <= strb_n;
      end
      if (accept) half_q <= half_n;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_strb));
  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_error |=> fmt_error);
  // R8
  bad_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && cls == CLS_BAD |=> !out_valid);
  // R6
  strb_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_strb & ~lane_mask) == '0);
  // R9
  word_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));
endmodule

// File: rtl/wbpk_packer.sv
module wbpk_packer
  import wbpk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  cfg_format,
  input  logic        cfg_alpha_store,
  input  logic        cfg_alpha_invert,
  input  logic [3:0]  cfg_lane_mask,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_alpha,
  input  logic [7:0]  in_red,
  input  logic [7:0]  in_green,
  input  logic [7:0]  in_blue,
  input  logic        in_eol,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic [3:0]  out_strb,
  output logic        fmt_error
);
  fmt_dec_t          dec;
  logic [WORD_W-1:0] pix_full;
  logic [HALF_W-1:0] pix_half;

  wbpk_fmt_decode u_dec (
    .code (cfg_format),
    .dec  (dec)
  );

  wbpk_convert u_conv (
    .dec          (dec),
    .alpha_store  (cfg_alpha_store),
    .alpha_invert (cfg_alpha_invert),
    .a_in         (in_alpha),
    .r_in         (in_red),
    .g_in         (in_green),
    .b_in         (in_blue),
    .pix_full     (pix_full),
    .pix_half     (pix_half)
  );

  wbpk_assembler u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cls       (dec.cls),
    .lane_mask (cfg_lane_mask),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_eol    (in_eol),
    .pix_full  (pix_full),
    .pix_half  (pix_half),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_strb  (out_strb),
    .fmt_error (fmt_error)
  );
endmodule

// File: tb/tb_wbpk_packer.sv
module tb_wbpk_packer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  cfg_format;
  logic        cfg_alpha_store, cfg_alpha_invert;
  logic [3:0]  cfg_lane_mask;
  logic        in_valid, in_ready, in_eol;
  logic [7:0]  in_alpha, in_red, in_green, in_blue;
  logic        out_valid, out_ready;
  logic [31:0] out_data;
  logic [3:0]  out_strb;
  logic        fmt_error;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  wbpk_packer dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_format(cfg_format), .cfg_alpha_store(cfg_alpha_store),
    .cfg_alpha_invert(cfg_alpha_invert), .cfg_lane_mask(cfg_lane_mask),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_alpha(in_alpha), .in_red(in_red), .in_green(in_green), .in_blue(in_blue),
    .in_eol(in_eol), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_strb(out_strb), .fmt_error(fmt_error)
  );

  typedef struct packed {
    logic [3:0]  fmt;
    logic        ast;
    logic        ainv;
    logic [3:0]  lane;
    logic [31:0] data;
    logic [3:0]  strb;
    logic [3:0]  req;
  } vec_t;

  // pixel 0: a=81 r=F2 g=63 b=34 ; pixel 1: a=1C r=A7 g=5E b=C9
  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{4'hD, 1'b1, 1'b0, 4'hF, 32'h81F26334, 4'hF, 4'd1},  // R1 ARGB
    '{4'hC, 1'b1, 1'b0, 4'hF, 32'h813463F2, 4'hF, 4'd1},  // R1 ABGR
    '{4'hE, 1'b1, 1'b0, 4'hF, 32'h3463F281, 4'hF, 4'd1},  // R1 BGRA
    '{4'hF, 1'b1, 1'b0, 4'hF, 32'hF2633481, 4'hF, 4'd1},  // R1 RGBA
    '{4'hD, 1'b1, 1'b1, 4'hF, 32'h7EF26334, 4'hF, 4'd4},  // R4 inverted alpha
    '{4'hD, 1'b0, 1'b1, 4'hF, 32'hFFF26334, 4'hF, 4'd5},  // R5 ones fill
    '{4'hD, 1'b0, 1'b0, 4'hF, 32'h00F26334, 4'hF, 4'd5},  // R5 zero fill
    '{4'hF, 1'b1, 1'b0, 4'h5, 32'hF2633481, 4'h5, 4'd6},  // R6 partial mask
    '{4'h1, 1'b1, 1'b0, 4'hF, 32'h1A5C8F63, 4'hF, 4'd2},  // R2 ARGB4444
    '{4'h0, 1'b1, 1'b0, 4'hF, 32'h1C5A836F, 4'hF, 4'd2},  // R2 ABGR4444
    '{4'h2, 1'b1, 1'b0, 4'hF, 32'hC5A136F8, 4'hF, 4'd2},  // R2 BGRA4444
    '{4'h3, 1'b1, 1'b0, 4'hF, 32'hA5C1F638, 4'hF, 4'd2},  // R2 RGBA4444
    '{4'h1, 1'b0, 1'b1, 4'hF, 32'hFA5CFF63, 4'hF, 4'd5},  // R5 4444 ones fill
    '{4'h3, 1'b1, 1'b1, 4'hF, 32'hA5CEF637, 4'hF, 4'd4},  // R4 4444 inverted
    '{4'h6, 1'b0, 1'b0, 4'hF, 32'hCAF4331E, 4'hF, 4'd3},  // R3 BGR565
    '{4'h7, 1'b1, 1'b0, 4'hE, 32'hA2F9F306, 4'hE, 4'd6},  // R6 R3 RGB565 mask
    '{4'h1, 1'b0, 1'b0, 4'hF, 32'h0A5C0F63, 4'hF, 4'd5}   // R5 4444 zero fill
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [3:0] f, input logic ast, input logic ainv, input logic [3:0] lane);
    @(posedge clk); #1;
    cfg_format = f; cfg_alpha_store = ast; cfg_alpha_invert = ainv; cfg_lane_mask = lane;
  endtask

  task automatic send(input logic [7:0] a, input logic [7:0] r, input logic [7:0] g,
                      input logic [7:0] b, input logic eol);
    @(negedge clk);
    in_valid = 1'b1; in_alpha = a; in_red = r; in_green = g; in_blue = b; in_eol = eol;
    @(posedge clk); #1;
    in_valid = 1'b0; in_eol = 1'b0;
    #1;
  endtask

  task automatic send_p0(input logic eol); send(8'h81, 8'hF2, 8'h63, 8'h34, eol); endtask
  task automatic send_p1(input logic eol); send(8'h1C, 8'hA7, 8'h5E, 8'hC9, eol); endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_eol = 1'b0; out_ready = 1'b1;
    in_alpha = '0; in_red = '0; in_green = '0; in_blue = '0;
    cfg_format = 4'hD; cfg_alpha_store = 1'b1; cfg_alpha_invert = 1'b0; cfg_lane_mask = 4'hF;
    repeat (3) @(posedge clk);
    #2;
    // R10 reset state
    chk("R10 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R10 fmt_error", {31'd0, fmt_error}, 32'd0);
    chk("R10 in_ready", {31'd0, in_ready}, 32'd1);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      set_cfg(VECS[i].fmt, VECS[i].ast, VECS[i].ainv, VECS[i].lane);
      if (VECS[i].fmt >= 4'd12) begin
        send_p0(1'b0);
      end else begin
        send_p0(1'b0);
        chk($sformatf("R%0d half word not yet out", VECS[i].req), {31'd0, out_valid}, 32'd0);
        send_p1(1'b0);
      end
      chk($sformatf("R%0d vec %0d valid", VECS[i].req, i), {31'd0, out_valid}, 32'd1);
      chk($sformatf("R%0d vec %0d data", VECS[i].req, i), out_data, VECS[i].data);
      chk($sformatf("R%0d vec %0d strb", VECS[i].req, i), {28'd0, out_strb}, {28'd0, VECS[i].strb});
    end

    // R7 lone pixel at end of line
    set_cfg(4'h7, 1'b0, 1'b0, 4'hF);
    send_p0(1'b1);
    chk("R7 odd valid", {31'd0, out_valid}, 32'd1);
    chk("R7 odd data", out_data, 32'h0000F306);
    chk("R7 odd strb", {28'd0, out_strb}, 32'h3);
    set_cfg(4'h7, 1'b0, 1'b0, 4'hD);
    send_p0(1'b1);
    chk("R7 R6 odd masked strb", {28'd0, out_strb}, 32'h1);

    // R10 half word dropped by reset
    set_cfg(4'h7, 1'b0, 1'b0, 4'hF);
    send_p0(1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    send_p1(1'b1);
    chk("R10 no pending half data", out_data, 32'h0000A2F9);
    chk("R10 no pending half strb", {28'd0, out_strb}, 32'h3);

    // R9 backpressure
    set_cfg(4'hD, 1'b1, 1'b0, 4'hF);
    @(negedge clk); out_ready = 1'b0;
    send_p0(1'b0);
    chk("R9 stalled valid", {31'd0, out_valid}, 32'd1);
    chk("R9 stalled in_ready", {31'd0, in_ready}, 32'd0);
    repeat (3) @(posedge clk);
    #2;
    chk("R9 held data", out_data, 32'h81F26334);
    chk("R9 still valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk); out_ready = 1'b1;
    @(posedge clk); #2;
    chk("R9 drained", {31'd0, out_valid}, 32'd0);

    // R8 unsupported code
    set_cfg(4'h9, 1'b1, 1'b0, 4'hF);
    for (int k = 0; k < 3; k++) begin
      chk("R8 in_ready under bad code", {31'd0, in_ready}, 32'd1);
      send_p0(1'b1);
      chk("R8 no word", {31'd0, out_valid}, 32'd0);
    end
    chk("R8 error set", {31'd0, fmt_error}, 32'd1);
    set_cfg(4'hD, 1'b1, 1'b0, 4'hF);
    send_p1(1'b0);
    chk("R8 error sticky", {31'd0, fmt_error}, 32'd1);
    chk("R8 R1 recovery data", out_data, 32'h1CA75EC9);
    @(negedge clk); rst_n = 1'b0;
    #2;
    chk("R10 error cleared", {31'd0, fmt_error}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule